// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns two raw active-low supply-monitor signals into an ordered set of reset outputs for a chip. It runs on a slow always-on clock. One monitor watches the backup supply and the other watches the main supply. The block drives a backup-domain reset, a processor reset, a peripheral reset and an external reset pin. It also drives a processor-clock enable and a small reset-cause field.

After the backup supply comes up, the backup reset is released first. A fixed oscillator-startup count follows, after which the processor clock is enabled. Three cycles after that, the processor and peripheral resets are released. The external pin is released after its own pulse, whose length is two raised to (exponent + 1) cycles. The exponent sits in a small mode register that the backup reset clears.

A drop of the backup monitor pulls every output low at once. A drop of the main monitor restarts the sequence and leaves the backup domain running.

Top module: `pors_top`

## Requirements
- R1: While `bkup_por_n` is low, `bkup_rst_n`, `cpu_rst_n`, `periph_rst_n`, `ext_rst_n` and `cpu_clk_en` are all 0. They fall without waiting for a clock edge, whatever `main_por_n` does.
- R2: `bkup_rst_n` rises after the second rising clock edge following the rise of `bkup_por_n`.
- R3: `cpu_clk_en` rises exactly STARTUP_CYC clock cycles after the sequence start. The sequence start is the rise of `bkup_rst_n`, or the point 2 edges after `main_por_n` rises on a restart. `cpu_rst_n` is never 1 while `cpu_clk_en` is 0.
- R4: `cpu_rst_n` and `periph_rst_n` rise on the same edge, exactly 3 cycles after `cpu_clk_en` rises.
- R5: `ext_rst_n` rises 2^(L+1) cycles after the sequence start, where L is the 4-bit pulse exponent. With L = 0 this is 2 cycles after `bkup_rst_n` rises. Once high, it stays high until the next reset.
- R6: The pulse exponent is written from `cfg_len` on any rising edge where `cfg_we` is 1. A backup reset returns it to 0.
- R7: `rst_cause` reads 3'd0 (general reset) after the backup reset and after the first sequence that follows it. It reads 3'd1 (main-supply restart) after any later sequence completes.
- R8: A low on `main_por_n` while `bkup_por_n` is high immediately forces `cpu_rst_n`, `periph_rst_n`, `ext_rst_n` and `cpu_clk_en` to 0, and `bkup_rst_n` stays 1. Once `main_por_n` rises again, the full sequence runs again with the timing of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| bkup_por_n | input | 1 | Backup supply monitor, active low |
| main_por_n | input | 1 | Main supply monitor, active low |
| cfg_we | input | 1 | Write enable for the pulse exponent |
| cfg_len | input | LEN_W | New pulse exponent value |
| bkup_rst_n | output | 1 | Backup-domain reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_n | output | 1 | External reset pin, active low |
| cpu_clk_en | output | 1 | Processor clock enable |
| rst_cause | output | 3 | Cause of the last completed reset |

## Verification
The assertions are checked on every cycle and cover four orderings:
- a low backup reset holds all other outputs low;
- a low main monitor holds every sequenced output low;
- the processor reset is never released without the clock enable, and is released exactly three cycles after it;
- the external pin never rises before the backup reset and stays high once released.

Some timing can only be shown by the bench's scenarios, which measure cycle counts after each release:
- the exact startup delay;
- the pulse length for each exponent value;
- clearing of the exponent by a backup reset;
- the cause codes;
- the fact that a main monitor held low while the backup monitor is low has no effect.

// File: rtl/pors_pkg.sv
package pors_pkg;
  typedef enum logic [1:0] {SQ_START, SQ_HOLD, SQ_DONE} sq_state_e;
  localparam logic [2:0] CAUSE_GENERAL = 3'd0;
  localparam logic [2:0] CAUSE_MAIN    = 3'd1;
endpackage

// File: rtl/pors_sync.sv
module pors_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic ok
);
  logic [STAGES-1:0] sh;

  // assertion is asynchronous, deassertion walks through STAGES flops
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign ok = sh[STAGES-1];
endmodule

// File: rtl/pors_fsm.sv
module pors_fsm
  import pors_pkg::*;
#(
  parameter int STARTUP_CYC = 64,
  parameter int HOLD_CYC    = 3
) (
  input  logic clk,
  input  logic clr_n,
  input  logic go,
  output logic clk_en,
  output logic cpu_rel,
  output logic per_rel,
  output logic done_p
);
  localparam int MAXC = (STARTUP_CYC > HOLD_CYC) ? STARTUP_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  sq_state_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      state   <= SQ_START;
      cnt     <= '0;
      clk_en  <= 1'b0;
      cpu_rel <= 1'b0;
      per_rel <= 1'b0;
    end else begin
      case (state)
        SQ_START: if (go) begin
          if (cnt == CW'(STARTUP_CYC - 1)) begin
            state  <= SQ_HOLD;
            cnt    <= '0;
            clk_en <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            state   <= SQ_DONE;
            cpu_rel <= 1'b1;
            per_rel <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_p = (state == SQ_HOLD) && (cnt == CW'(HOLD_CYC - 1));

  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(cpu_rel) |-> ($past(clk_en, 3) && !$past(clk_en, 4)));

  // R3
  clk_en_first_chk: assert property (@(posedge clk) disable iff (!clr_n)
    cpu_rel |-> clk_en);
endmodule

// File: rtl/pors_ext.sv
module pors_ext #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  output logic             ext_rel
);
  localparam int CW  = (1 << LEN_W) + 1;
  localparam int LW1 = LEN_W + 1;

  logic [LW1-1:0] shamt;
  logic [CW-1:0]  lim;
  logic [CW-1:0]  cnt;

  assign shamt = {1'b0, len} + LW1'(1);
  assign lim   = (CW'(1) << shamt) - CW'(1);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt     <= '0;
      ext_rel <= 1'b0;
    end else if (go && !ext_rel) begin
      if (cnt == lim) ext_rel <= 1'b1;
      else            cnt     <= cnt + 1'b1;
    end
  end

  // R5
  ext_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ext_rel |=> ext_rel);
endmodule

// File: rtl/pors_top.sv
module pors_top
  import pors_pkg::*;
#(
  parameter int STARTUP_CYC = 64,
  parameter int HOLD_CYC    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 4
) (
  input  logic             clk,
  input  logic             bkup_por_n,
  input  logic             main_por_n,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             bkup_rst_n,
  output logic             cpu_rst_n,
  output logic             periph_rst_n,
  output logic             ext_rst_n,
  output logic             cpu_clk_en,
  output logic [2:0]       rst_cause
);
  logic             run_n;
  logic             b_ok, m_ok, go, done_p, seen;
  logic [LEN_W-1:0] len_q;

  assign run_n = bkup_por_n & main_por_n;

  pors_sync #(.STAGES(SYNC_STAGES)) u_bsync (.clk(clk), .clr_n(bkup_por_n), .ok(b_ok));
  pors_sync #(.STAGES(SYNC_STAGES)) u_msync (.clk(clk), .clr_n(run_n),      .ok(m_ok));

  assign bkup_rst_n = b_ok;
  assign go         = b_ok & m_ok;

  // mode register lives in the backup domain
  always_ff @(posedge clk or negedge bkup_por_n) begin
    if (!bkup_por_n)  len_q <= '0;
    else if (cfg_we)  len_q <= cfg_len;
  end

  pors_fsm #(.STARTUP_CYC(STARTUP_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .clr_n(run_n), .go(go), .clk_en(cpu_clk_en),
    .cpu_rel(cpu_rst_n), .per_rel(periph_rst_n), .done_p(done_p)
  );

  pors_ext #(.LEN_W(LEN_W)) u_ext (
    .clk(clk), .clr_n(run_n), .go(go), .len(len_q), .ext_rel(ext_rst_n)
  );

  always_ff @(posedge clk or negedge bkup_por_n) begin
    if (!bkup_por_n) begin
      rst_cause <= CAUSE_GENERAL;
      seen      <= 1'b0;
    end else if (done_p) begin
      rst_cause <= seen ? CAUSE_MAIN : CAUSE_GENERAL;
      seen      <= 1'b1;
    end
  end

  // R1
  bkup_all_chk: assert property (@(posedge clk) disable iff (!bkup_por_n)
    !bkup_rst_n |-> (!cpu_rst_n && !periph_rst_n && !ext_rst_n && !cpu_clk_en));

  // R8
  main_drop_chk: assert property (@(posedge clk) disable iff (!bkup_por_n)
    !main_por_n |-> (!cpu_rst_n && !periph_rst_n && !ext_rst_n && !cpu_clk_en));

  // R5
  ext_after_bkup_chk: assert property (@(posedge clk) disable iff (!bkup_por_n)
    $rose(ext_rst_n) |-> (bkup_rst_n && $past(bkup_rst_n)));
endmodule

// File: tb/tb_pors_top.sv
`timescale 1ns/1ps
module tb_pors_top;
  localparam int S = 5;
  localparam int NV = 5;
  localparam logic [3:0] LENS [NV] = '{4'd1, 4'd0, 4'd2, 4'd3, 4'd5};
  localparam int         EXT  [NV] = '{6, 4, 10, 18, 66};

  logic clk = 1'b0;
  logic bkup_por_n = 1'b0, main_por_n = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_len = '0;
  logic bkup_rst_n, cpu_rst_n, periph_rst_n, ext_rst_n, cpu_clk_en;
  logic [2:0] rst_cause;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pors_top #(.STARTUP_CYC(S)) dut (
    .clk(clk), .bkup_por_n(bkup_por_n), .main_por_n(main_por_n),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .bkup_rst_n(bkup_rst_n),
    .cpu_rst_n(cpu_rst_n), .periph_rst_n(periph_rst_n), .ext_rst_n(ext_rst_n),
    .cpu_clk_en(cpu_clk_en), .rst_cause(rst_cause)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs_low(string req);
    chk(req, "cpu_rst_n", cpu_rst_n, 0);
    chk(req, "periph_rst_n", periph_rst_n, 0);
    chk(req, "ext_rst_n", ext_rst_n, 0);
    chk(req, "cpu_clk_en", cpu_clk_en, 0);
  endtask

  task automatic measure(output int tb, output int tce, output int tcpu,
                         output int tper, output int text);
    tb = -1; tce = -1; tcpu = -1; tper = -1; text = -1;
    for (int i = 1; i <= 120; i++) begin
      @(negedge clk);
      if (tb   < 0 && bkup_rst_n)   tb   = i;
      if (tce  < 0 && cpu_clk_en)   tce  = i;
      if (tcpu < 0 && cpu_rst_n)    tcpu = i;
      if (tper < 0 && periph_rst_n) tper = i;
      if (text < 0 && ext_rst_n)    text = i;
    end
  endtask

  task automatic write_len(logic [3:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_len = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int tb, tce, tcpu, tper, text;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "bkup_rst_n", bkup_rst_n, 0);
    outs_low("R1");
    chk("R7", "cause at reset", rst_cause, 0);

    // R1: main supply up while backup monitor low has no effect
    main_por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "bkup_rst_n main only", bkup_rst_n, 0);
    outs_low("R1");

    // general reset release
    bkup_por_n = 1'b1;
    measure(tb, tce, tcpu, tper, text);
    chk("R2", "bkup_rst_n edges", tb, 2);
    chk("R3", "clk_en edges", tce, S + 2);
    chk("R4", "cpu_rst_n edges", tcpu, S + 5);
    chk("R4", "periph_rst_n edges", tper, S + 5);
    chk("R5", "ext default edges", text, 4);
    chk("R7", "cause general", rst_cause, 0);

    // table walk: exponent values over main-supply restarts
    for (int k = 0; k < NV; k++) begin
      write_len(LENS[k]);
      @(negedge clk); main_por_n = 1'b0;
      #0.5;
      outs_low("R8");
      chk("R8", "bkup stays", bkup_rst_n, 1);
      @(negedge clk); @(negedge clk); main_por_n = 1'b1;
      measure(tb, tce, tcpu, tper, text);
      chk("R8", "bkup held high", tb, 1);
      chk("R3", "restart clk_en", tce, S + 2);
      chk("R4", "restart cpu", tcpu, S + 5);
      chk("R4", "restart periph", tper, S + 5);
      chk("R5", "ext pulse", text, EXT[k]);
      chk("R7", "cause main", rst_cause, 1);
    end

    // R1 asynchronous drop during hold phase
    @(negedge clk); main_por_n = 1'b0;
    @(negedge clk); main_por_n = 1'b1;
    repeat (S + 3) @(negedge clk);
    chk("R3", "clk_en in hold", cpu_clk_en, 1);
    #0.5 bkup_por_n = 1'b0;
    #0.5;
    chk("R1", "bkup_rst_n async", bkup_rst_n, 0);
    outs_low("R1");
    chk("R6", "cause cleared", rst_cause, 0);

    // R6: exponent returned to 0 by backup reset
    repeat (2) @(negedge clk);
    bkup_por_n = 1'b1;
    measure(tb, tce, tcpu, tper, text);
    chk("R2", "bkup_rst_n again", tb, 2);
    chk("R6", "ext default after bkup", text, 4);
    chk("R7", "cause general again", rst_cause, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule